// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that follows a chain of buffer descriptors kept in memory. Software writes the address of the first descriptor with the go bit set. The channel then reads that four-word descriptor and serves peripheral requests one data word at a time, moving words either from the peripheral into the buffer or from the buffer out to the peripheral. A buffer closes when its length counter runs out or when the peripheral flags end-of-frame on a request, whichever comes first.

When a buffer closes, the channel updates the descriptor according to a two-bit writeback mode. It then follows the next-descriptor pointer, or stops if the descriptor asked it to. Memory is reached through a simple request port whose reads return data one cycle later.

Descriptor layout, by byte offset from the descriptor address:
- +0: next-descriptor address.
- +4: buffer address.
- +8: the low 16 bits hold the length; the upper bits are kept as they are.
- +12: the control/status word, laid out as follows:
  - bit 0: enable.
  - bits 2:1: writeback mode.
  - bit 3: halt.
  - bit 4: stop-at-end-of-frame.
  - bit 5: direction (0 = peripheral to memory, 1 = memory to peripheral).
  - bits 31:16: status field.

Top module: `desc_dma_chan`

## Requirements
- R1: After reset, `busy`, `done`, `halted` and `err` are low and `mem_req` is low.
- R2: A `cfg_wr` with `cfg_go` high while idle starts the channel at the written address. Its first memory read is the control/status word at offset +12, followed by offsets +0, +4 and +8.
- R3: If the enable bit (bit 0) of a fetched control/status word is clear, the channel returns to idle with `err` high. It makes no transfer and no descriptor write, and it raises no `done`.
- R4: With direction bit 5 clear, each `per_req` is acknowledged by `per_ack` in the same cycle. That cycle writes `per_wdata` to the buffer address, and the buffer address then advances by 4.
- R5: With direction bit 5 set, each request causes a read of the buffer word. That word appears on `per_rdata` in the cycle `per_ack` is high, and the buffer address then advances by 4.
- R6: The buffer closes after the transfer that brings the remaining length to zero, or after a transfer whose request carries `per_eof`. No buffer word beyond that point is touched.
- R7: Writeback mode 00 rewrites the control/status word with bit 0 cleared and every other bit kept. The length word is not written.
- R8: Writeback mode 01 holds `per_stat_req` high until `per_stat_valid` is seen. It then writes the number of words moved into length bits 15:0, keeping the upper bits. Finally it rewrites the control/status word with bit 0 cleared and bits 31:16 replaced by `per_stat`.
- R9: Writeback modes 10 and 11 leave all four descriptor words unchanged.
- R10: `done` is a single-cycle pulse given exactly once for each closed buffer, including when `per_eof` arrives with the last counted transfer.
- R11: If halt (bit 3) or stop-at-end-of-frame (bit 4) is set, the channel goes idle after the close with `halted` high. Otherwise it fetches the descriptor at the next-descriptor address.
- R12: A `cfg_wr` while the channel is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_go | input | 1 | Start bit written with the address |
| cfg_list_addr | input | AW | First descriptor address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |
| per_req | input | 1 | Peripheral transfer request |
| per_eof | input | 1 | End-of-frame, qualified by `per_req` |
| per_wdata | input | 32 | Data from the peripheral |
| per_ack | output | 1 | Transfer acknowledge |
| per_rdata | output | 32 | Data to the peripheral, valid with `per_ack` |
| per_stat_req | output | 1 | Status request for writeback mode 01 |
| per_stat_valid | input | 1 | Status value is present |
| per_stat | input | SW | Peripheral status value |
| busy | output | 1 | Channel is active |
| done | output | 1 | Buffer-closed pulse |
| halted | output | 1 | Chaining stopped by a descriptor bit |
| err | output | 1 | A disabled descriptor was fetched |

## Verification
The checks assume a peripheral that keeps `per_req` and `per_eof` steady until it sees `per_ack`. They also assume that `per_stat_valid` is given only while `per_stat_req` is high, and that the memory answers every read in the following cycle. The bench drives each request at the falling edge and holds it until the acknowledge has been taken at a rising edge. Its status responder raises `per_stat_valid` only in reply to a pending status request, and its memory model returns read data one cycle after the request.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_XFER, S_MRD,
    S_CLOSE, S_STAT, S_WB_LEN, S_WB_CS, S_DONE
  } dma_st_e;

  // control/status bit positions
  localparam int CS_EN      = 0;
  localparam int CS_WB      = 1;
  localparam int CS_HALT    = 3;
  localparam int CS_EOFSTOP = 4;
  localparam int CS_DIR     = 5;

  // descriptor word indices
  localparam logic [1:0] WD_NEXT = 2'd0;
  localparam logic [1:0] WD_BUF  = 2'd1;
  localparam logic [1:0] WD_LEN  = 2'd2;
  localparam logic [1:0] WD_CS   = 2'd3;

  // fetch step 0 reads the control/status word, then words 0,1,2
  function automatic logic [1:0] fetch_word(input logic [1:0] step);
    return step - 2'd1;
  endfunction
endpackage

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       rd_en_bit,
  input  logic       rem_zero,
  input  logic       rem_one,
  input  logic       dir,
  input  logic [1:0] wb_mode,
  input  logic       stop_req,
  input  logic       per_req,
  input  logic       per_eof,
  input  logic       per_stat_valid,
  output dma_st_e    st,
  output logic [1:0] step,
  output logic       fire,
  output logic       halted,
  output logic       err
);
  dma_st_e nxt;
  logic    last;

  assign fire = (st == S_XFER && !dir && per_req && !rem_zero) || (st == S_MRD);
  assign last = rem_one || per_eof;

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:   if (start) nxt = S_FETCH;
      S_FETCH:  nxt = S_FWAIT;
      S_FWAIT: begin
        if (step == 2'd0 && !rd_en_bit) nxt = S_IDLE;
        else if (step == 2'd3)          nxt = S_XFER;
        else                            nxt = S_FETCH;
      end
      S_XFER: begin
        if (rem_zero)     nxt = S_CLOSE;
        else if (per_req) nxt = dir ? S_MRD : (last ? S_CLOSE : S_XFER);
      end
      S_MRD:    nxt = last ? S_CLOSE : S_XFER;
      S_CLOSE: begin
        case (wb_mode)
          2'b00:   nxt = S_WB_CS;
          2'b01:   nxt = S_STAT;
          default: nxt = S_DONE;
        endcase
      end
      S_STAT:   if (per_stat_valid) nxt = S_WB_LEN;
      S_WB_LEN: nxt = S_WB_CS;
      S_WB_CS:  nxt = S_DONE;
      S_DONE:   nxt = stop_req ? S_IDLE : S_FETCH;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      step   <= 2'd0;
      halted <= 1'b0;
      err    <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && start) begin
        step   <= 2'd0;
        halted <= 1'b0;
        err    <= 1'b0;
      end
      if (st == S_FWAIT) begin
        step <= step + 2'd1;
        if (step == 2'd0 && !rd_en_bit) err <= 1'b1;
      end
      if (st == S_DONE) begin
        step <= 2'd0;
        if (stop_req) halted <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int SW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dma_st_e           st,
  input  logic [1:0]        step,
  input  logic              start,
  input  logic [AW-1:0]     cfg_list_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              fire,
  input  logic              per_stat_valid,
  input  logic [SW-1:0]     per_stat,
  output logic [AW-1:0]     desc_ptr,
  output logic [AW-1:0]     buf_ptr,
  output logic [WORD_W-1:0] len_w,
  output logic [WORD_W-1:0] cs_w,
  output logic [LW-1:0]     cnt,
  output logic [SW-1:0]     stat,
  output logic              rem_zero,
  output logic              rem_one
);
  localparam int          STEP_B = WORD_W / 8;
  localparam logic [AW-1:0] STEP = AW'(STEP_B);

  logic [AW-1:0] next_ptr;
  logic [LW-1:0] rem;

  assign rem_zero = (rem == '0);
  assign rem_one  = (rem == LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_ptr <= '0;
      next_ptr <= '0;
      buf_ptr  <= '0;
      len_w    <= '0;
      cs_w     <= '0;
      rem      <= '0;
      cnt      <= '0;
      stat     <= '0;
    end else begin
      if (st == S_IDLE && start) desc_ptr <= cfg_list_addr;
      if (st == S_FWAIT) begin
        case (fetch_word(step))
          WD_NEXT: next_ptr <= mem_rdata[AW-1:0];
          WD_BUF:  buf_ptr  <= mem_rdata[AW-1:0];
          WD_LEN: begin
            len_w <= mem_rdata;
            rem   <= mem_rdata[LW-1:0];
            cnt   <= '0;
          end
          default: cs_w <= mem_rdata;
        endcase
      end
      if (fire) begin
        buf_ptr <= buf_ptr + STEP;
        rem     <= rem - LW'(1);
        cnt     <= cnt + LW'(1);
      end
      if (st == S_STAT && per_stat_valid) stat <= per_stat;
      if (st == S_DONE) desc_ptr <= next_ptr;
    end
  end
endmodule

// File: rtl/desc_dma_chan.sv
module desc_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int SW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_go,
  input  logic [AW-1:0]     cfg_list_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              per_req,
  input  logic              per_eof,
  input  logic [WORD_W-1:0] per_wdata,
  output logic              per_ack,
  output logic [WORD_W-1:0] per_rdata,
  output logic              per_stat_req,
  input  logic              per_stat_valid,
  input  logic [SW-1:0]     per_stat,
  output logic              busy,
  output logic              done,
  output logic              halted,
  output logic              err
);
  dma_st_e          st;
  logic [1:0]       step;
  logic             fire, rem_zero, rem_one, start;
  logic [AW-1:0]    desc_ptr, buf_ptr;
  logic [WORD_W-1:0] len_w, cs_w;
  logic [LW-1:0]    cnt;
  logic [SW-1:0]    stat;

  assign start = cfg_wr && cfg_go;

  dma_chan_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .rd_en_bit(mem_rdata[CS_EN]),
    .rem_zero(rem_zero), .rem_one(rem_one), .dir(cs_w[CS_DIR]),
    .wb_mode(cs_w[CS_WB+1:CS_WB]),
    .stop_req(cs_w[CS_HALT] || cs_w[CS_EOFSTOP]),
    .per_req(per_req), .per_eof(per_eof), .per_stat_valid(per_stat_valid),
    .st(st), .step(step), .fire(fire), .halted(halted), .err(err)
  );

  dma_chan_dp #(.AW(AW), .LW(LW), .SW(SW)) u_dp (
    .clk(clk), .rst(rst), .st(st), .step(step), .start(start),
    .cfg_list_addr(cfg_list_addr), .mem_rdata(mem_rdata), .fire(fire),
    .per_stat_valid(per_stat_valid), .per_stat(per_stat),
    .desc_ptr(desc_ptr), .buf_ptr(buf_ptr), .len_w(len_w), .cs_w(cs_w),
    .cnt(cnt), .stat(stat), .rem_zero(rem_zero), .rem_one(rem_one)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_ptr + AW'({fetch_word(step), 2'b00});
      end
      S_XFER: begin
        if (per_req && !rem_zero) begin
          mem_req   = 1'b1;
          mem_we    = !cs_w[CS_DIR];
          mem_addr  = buf_ptr;
          mem_wdata = per_wdata;
        end
      end
      S_WB_LEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_ptr + AW'({WD_LEN, 2'b00});
        mem_wdata = {len_w[WORD_W-1:LW], cnt};
      end
      S_WB_CS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_ptr + AW'({WD_CS, 2'b00});
        mem_wdata = (cs_w[CS_WB+1:CS_WB] == 2'b01) ?
                    {stat, cs_w[WORD_W-SW-1:1], 1'b0} : {cs_w[WORD_W-1:1], 1'b0};
      end
      default: ;
    endcase
  end

  assign per_ack      = fire;
  assign per_rdata    = mem_rdata;
  assign per_stat_req = (st == S_STAT);
  assign busy         = (st != S_IDLE);
  assign done         = (st == S_DONE);
endmodule

// File: rtl/desc_dma_chan_chk.sv
module desc_dma_chan_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic halted,
  input logic err,
  input logic mem_req,
  input logic mem_we,
  input logic per_req,
  input logic per_ack,
  input logic per_stat_req,
  input logic per_stat_valid
);
  // R10: done never lasts two cycles
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: acknowledge only answers a pending request
  a_r4_ack_on_req: assert property (@(posedge clk) disable iff (rst)
    per_ack |-> per_req);
  // R8: status request stays up until answered
  a_r8_stat_hold: assert property (@(posedge clk) disable iff (rst)
    (per_stat_req && !per_stat_valid) |=> per_stat_req);
  // R3: an error stop leaves the channel idle
  a_r3_err_idle: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);
  // R11: a halted channel is idle
  a_r11_halt_idle: assert property (@(posedge clk) disable iff (rst)
    halted |-> !busy);
  // R1: no memory traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
  // R4: a write is always part of a request
  a_r4_we_in_req: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
endmodule

bind desc_dma_chan desc_dma_chan_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .halted(halted), .err(err),
  .mem_req(mem_req), .mem_we(mem_we), .per_req(per_req), .per_ack(per_ack),
  .per_stat_req(per_stat_req), .per_stat_valid(per_stat_valid)
);

// File: tb/desc_dma_chan_tb_top.sv
module desc_dma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_go = 1'b0;
  logic [31:0] cfg_list_addr = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        per_req = 1'b0, per_eof = 1'b0;
  logic [31:0] per_wdata = '0;
  logic        per_ack;
  logic [31:0] per_rdata;
  logic        per_stat_req;
  logic        per_stat_valid = 1'b0;
  logic [15:0] per_stat = 16'hA5C3;
  logic        busy, done, halted, err;

  logic [31:0] mem [0:255];
  int errors = 0, checks = 0, done_cnt = 0;
  logic [31:0] first_rd = '0;
  logic        watch_rd = 1'b0;

  always #5 clk = ~clk;

  desc_dma_chan dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_go(cfg_go), .cfg_list_addr(cfg_list_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .per_req(per_req), .per_eof(per_eof), .per_wdata(per_wdata),
    .per_ack(per_ack), .per_rdata(per_rdata), .per_stat_req(per_stat_req),
    .per_stat_valid(per_stat_valid), .per_stat(per_stat), .busy(busy), .done(done),
    .halted(halted), .err(err)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    if (done) done_cnt <= done_cnt + 1;
    if (watch_rd && mem_req && !mem_we) begin
      first_rd <= mem_addr;
      watch_rd <= 1'b0;
    end
  end

  // status responder: answers a pending status request for one cycle
  initial forever begin
    @(negedge clk);
    per_stat_valid = per_stat_req && !per_stat_valid;
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cs(input bit en, input bit [1:0] wb, input bit hlt,
                                        input bit eofs, input bit dir);
    return {16'h1234, 10'h0, dir, eofs, hlt, wb, en};
  endfunction

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic put_desc(input logic [31:0] at, input logic [31:0] nx, input logic [31:0] bf,
                          input logic [31:0] ln, input logic [31:0] cs);
    mem[at[9:2]]     = nx;
    mem[at[9:2] + 1] = bf;
    mem[at[9:2] + 2] = ln;
    mem[at[9:2] + 3] = cs;
  endtask

  task automatic start(input logic [31:0] a);
    @(negedge clk);
    done_cnt = 0;
    watch_rd = 1'b1;
    cfg_list_addr = a; cfg_wr = 1'b1; cfg_go = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_go = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] d, input bit e, output logic [31:0] got);
    per_req = 1'b1; per_wdata = d; per_eof = e;
    forever begin
      #1;
      if (per_ack) begin
        got = per_rdata;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    per_req = 1'b0; per_eof = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 halted/err", {30'b0, halted, err}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
  endtask

  task automatic t_p2m_mode00();
    logic [31:0] g;
    logic [31:0] cs = mk_cs(1, 2'b00, 1, 0, 0);
    put_desc(32'h100, 32'h140, 32'h200, 32'hBEEF_0003, cs);
    for (int i = 0; i < 4; i++) mem[8'h80 + i] = 32'h0;
    put_desc(32'h180, 32'h0, 32'h0, 32'h1, mk_cs(0, 0, 0, 0, 0));
    start(32'h100);
    xfer(32'hAAAA_0001, 0, g);
    cfg_list_addr = 32'h180; cfg_wr = 1'b1; cfg_go = 1'b1;   // R12 ignored while busy
    @(negedge clk);
    cfg_wr = 1'b0; cfg_go = 1'b0;
    xfer(32'hAAAA_0002, 0, g);
    xfer(32'hAAAA_0003, 0, g);
    wait_idle();
    chk("R2 first read at cs word", first_rd, 32'h10C);
    chk("R4 word0", rd(32'h200), 32'hAAAA_0001);
    chk("R4 word2", rd(32'h208), 32'hAAAA_0003);
    chk("R6 stop at zero length", rd(32'h20C), 32'h0);
    chk("R7 cs enable cleared", rd(32'h10C), cs & ~32'h1);
    chk("R7 length untouched", rd(32'h108), 32'hBEEF_0003);
    chk("R11 halted", {31'b0, halted}, 32'd1);
    chk("R12 write while busy ignored", {31'b0, err}, 32'd0);
    chk("R10 one done", done_cnt, 32'd1);
  endtask

  task automatic t_eof_mode01();
    logic [31:0] g;
    logic [31:0] cs = mk_cs(1, 2'b01, 1, 0, 0);
    put_desc(32'h100, 32'h140, 32'h200, 32'hC0DE_0005, cs);
    mem[8'h82] = 32'hDEAD_0000;
    start(32'h100);
    xfer(32'h5555_0001, 0, g);
    xfer(32'h5555_0002, 1, g);
    wait_idle();
    chk("R6 eof closes early", rd(32'h208), 32'hDEAD_0000);
    chk("R8 length written", rd(32'h108), 32'hC0DE_0002);
    chk("R8 cs with status", rd(32'h10C), {16'hA5C3, cs[15:1], 1'b0});
    chk("R10 one done", done_cnt, 32'd1);
  endtask

  task automatic t_eof_last();
    logic [31:0] g;
    logic [31:0] cs = mk_cs(1, 2'b00, 1, 0, 0);
    put_desc(32'h100, 32'h140, 32'h200, 32'h0000_0002, cs);
    mem[8'h82] = 32'h7777_7777;
    start(32'h100);
    xfer(32'h6666_0001, 0, g);
    xfer(32'h6666_0002, 1, g);
    repeat (5) @(negedge clk);
    wait_idle();
    chk("R10 eof on last count gives one done", done_cnt, 32'd1);
    chk("R6 nothing past last", rd(32'h208), 32'h7777_7777);
    chk("R7 cs cleared", rd(32'h10C), cs & ~32'h1);
  endtask

  task automatic t_chain();
    logic [31:0] g;
    logic [31:0] csa = mk_cs(1, 2'b10, 0, 0, 0);
    logic [31:0] csb = mk_cs(1, 2'b00, 0, 1, 1);
    put_desc(32'h100, 32'h140, 32'h200, 32'h0000_0001, csa);
    put_desc(32'h140, 32'h180, 32'h300, 32'h0000_0002, csb);
    put_desc(32'h180, 32'h0, 32'h0, 32'h1, mk_cs(0, 0, 0, 0, 0));
    mem[8'hC0] = 32'h1111_0000;
    mem[8'hC1] = 32'h2222_0000;
    start(32'h100);
    xfer(32'h9999_0001, 0, g);
    xfer(32'h0, 0, g);
    chk("R5 first read word", g, 32'h1111_0000);
    xfer(32'h0, 0, g);
    chk("R5 second read word", g, 32'h2222_0000);
    wait_idle();
    chk("R4 chained buffer write", rd(32'h200), 32'h9999_0001);
    chk("R9 cs unchanged", rd(32'h10C), csa);
    chk("R9 length unchanged", rd(32'h108), 32'h0000_0001);
    chk("R7 second cs cleared", rd(32'h14C), csb & ~32'h1);
    chk("R11 eof-stop halts, no further fetch", {30'b0, halted, err}, 32'd2);
    chk("R10 two dones", done_cnt, 32'd2);
  endtask

  task automatic t_disabled();
    logic [31:0] cs = mk_cs(0, 2'b00, 0, 0, 0);
    put_desc(32'h180, 32'h100, 32'h200, 32'h0000_0004, cs);
    mem[8'h80] = 32'h4444_4444;
    start(32'h180);
    wait_idle();
    chk("R3 err set", {30'b0, halted, err}, 32'd1);
    chk("R3 no done", done_cnt, 32'd0);
    chk("R3 cs untouched", rd(32'h18C), cs);
    chk("R3 buffer untouched", rd(32'h200), 32'h4444_4444);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_p2m_mode00();
    t_eof_mode01();
    t_eof_last();
    t_chain();
    t_disabled();
    finish_run();
  end
endmodule